// File: doc/BRIEF.md
# Sticky Interrupt Status Controller

This block is the alarm and interrupt logic of a clock generator. It watches four live alarm conditions, each arriving as a plain asynchronous level: initialization still running, loss of lock on the second PLL, loss of lock on the first PLL, and loss of the input signal. A PLL reports loss of lock when its reference lies outside the lock range or is not a valid input signal. Every alarm passes through a two-flop synchronizer and a rising-edge detector. Each rising edge sets a sticky latch, and that latch holds until software clears it.

Software reaches three byte-wide registers through a simple register port. A write takes effect on the clock edge where `reg_wr_en` is high. A read is combinational from `reg_addr`. The three registers are the live view, the sticky latches and a per-alarm mask. The mask only gates the active-low, open-drain style interrupt pin. It never stops a sticky latch from capturing. All ports are plain control and status signals, so there is no handshake or back-pressure at the edge of the block.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: After reset the sticky and mask registers read 0x00 and `irq_n` is high.
- R2: Register address 0 returns the synchronized live alarms: bit 7 is init-busy (`alarm_in[3]`), bit 6 is second-PLL unlocked (`alarm_in[2]`), bit 5 is first-PLL unlocked (`alarm_in[1]`) and bit 4 is signal lost (`alarm_in[0]`). An input change shows there after the second rising clock edge.
- R3: A rising edge on an alarm input sets its sticky bit, at the same bit position, at address 1. The bit is set after the third rising clock edge.
- R4: A sticky bit stays set after its live alarm returns low.
- R5: Writing 1 to a sticky bit clears it. Writing 0 to a sticky bit leaves it unchanged.
- R6: When a clear write and a new rising edge hit the same sticky bit on the same edge, the bit ends up set.
- R7: `irq_n` is low exactly when some sticky bit is set and the mask bit at the same position (address 2, bits 7..4) is 0. A mask bit of 1 blocks that alarm from the pin.
- R8: Masking an alarm does not stop its sticky bit from setting.
- R9: Writes to address 0 have no effect. Bits 3..0 of every register and all of address 3 read as zero.
- R10: An alarm held high sets its sticky bit only once. After a clear, the bit stays 0 until the alarm falls and rises again.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alarm_in | input | 4 | Raw alarm levels: [3] init busy, [2] second-PLL unlocked, [1] first-PLL unlocked, [0] signal lost |
| reg_addr | input | 2 | Register select: 0 live, 1 sticky, 2 mask, 3 reserved |
| reg_wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wr_data | input | 8 | Write data |
| reg_rd_data | output | 8 | Read data for `reg_addr` |
| irq_n | output | 1 | Interrupt, low while any unmasked sticky bit is set |

## Verification
A sticky latch in the wrong state shows up at the pin in the same cycle, as `irq_n` out of step with the sticky and mask reads. It also shows in the next read of address 1. A broken edge detector shows up three cycles after a write that clears a sticky bit while its alarm stays high: the bit comes back. A synchronizer with the wrong depth shifts the live and sticky reads by one cycle, which the cycle-exact sampling catches at once. A lost or spurious set caused by a clear/set race appears as the value read back right after the colliding edge.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  typedef enum logic [1:0] {
    ADDR_LIVE   = 2'd0,
    ADDR_STICKY = 2'd1,
    ADDR_MASK   = 2'd2,
    ADDR_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int N      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] level,
  output logic [N-1:0] rise
);
  for (genvar gi = 0; gi < N; gi++) begin : g_bit
    logic [STAGES-1:0] chain;
    logic              prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '0;
        prev  <= 1'b0;
      end else begin
        chain <= {chain[STAGES-2:0], raw[gi]};
        prev  <= chain[STAGES-1];
      end
    end
    assign level[gi] = chain[STAGES-1];
    assign rise[gi]  = chain[STAGES-1] & ~prev;
  end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] sticky
);
  // a new edge wins over a clear landing on the same edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sticky <= '0;
    else        sticky <= (sticky & ~clr_i) | set_i;
  end
endmodule

// File: rtl/alarm_irq_drv.sv
module alarm_irq_drv #(
  parameter int N = 4
) (
  input  logic [N-1:0] sticky,
  input  logic [N-1:0] mask,
  output logic         irq_n
);
  logic [N-1:0] pending;
  assign pending = sticky & ~mask;
  assign irq_n   = ~(|pending);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl #(
  parameter int NUM_ALARMS  = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_ALARMS-1:0] alarm_in,
  input  logic [1:0]            reg_addr,
  input  logic                  reg_wr_en,
  input  logic [DATA_W-1:0]     reg_wr_data,
  output logic [DATA_W-1:0]     reg_rd_data,
  output logic                  irq_n
);
  import alarm_irq_pkg::*;

  localparam int ALARM_LSB = DATA_W - NUM_ALARMS;

  logic [NUM_ALARMS-1:0] live_q, rise_w, sticky_q, mask_q, clr_w, wr_field;
  logic wr_sticky, wr_mask;

  assign wr_field  = reg_wr_data[DATA_W-1:ALARM_LSB];
  assign wr_sticky = reg_wr_en && (reg_addr == ADDR_STICKY);
  assign wr_mask   = reg_wr_en && (reg_addr == ADDR_MASK);
  assign clr_w     = wr_sticky ? wr_field : '0;

  alarm_sync #(.N(NUM_ALARMS), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .raw(alarm_in), .level(live_q), .rise(rise_w)
  );

  sticky_bank #(.N(NUM_ALARMS)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_i(rise_w), .clr_i(clr_w), .sticky(sticky_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= wr_field;
  end

  alarm_irq_drv #(.N(NUM_ALARMS)) drv_i (
    .sticky(sticky_q), .mask(mask_q), .irq_n(irq_n)
  );

  always_comb begin
    reg_rd_data = '0;
    case (reg_addr)
      ADDR_LIVE:   reg_rd_data[DATA_W-1:ALARM_LSB] = live_q;
      ADDR_STICKY: reg_rd_data[DATA_W-1:ALARM_LSB] = sticky_q;
      ADDR_MASK:   reg_rd_data[DATA_W-1:ALARM_LSB] = mask_q;
      default:     reg_rd_data = '0;
    endcase
  end
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk #(
  parameter int N      = 4,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_addr,
  input logic              reg_wr_en,
  input logic [DATA_W-1:0] reg_rd_data,
  input logic              irq_n,
  input logic [N-1:0]      live,
  input logic [N-1:0]      sticky,
  input logic [N-1:0]      mask
);
  localparam int LSB = DATA_W - N;

  // R4: without a write to the sticky address no sticky bit drops
  p_sticky_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_addr == 2'd1) |=> ((sticky & $past(sticky)) == $past(sticky)));

  // R3: a sticky bit only appears where the live alarm was high
  p_sticky_from_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky & ~$past(sticky) & ~$past(live)) == '0));

  // R9: a write to the live address leaves the mask alone
  p_live_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == 2'd0) |=> $stable(mask));

  // R9: reserved low bits read zero
  p_rsvd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[LSB-1:0] == '0));

  // R7: fully masked means the pin stays released
  p_mask_all_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask) |-> irq_n);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(.N(NUM_ALARMS), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
  .reg_rd_data(reg_rd_data), .irq_n(irq_n),
  .live(live_q), .sticky(sticky_q), .mask(mask_q)
);

// File: tb/alarm_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] alarm_in = 4'h0;
  logic [1:0] reg_addr = 2'd0;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_data = 8'h00;
  logic [7:0] reg_rd_data;
  logic       irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alarm_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .alarm_in(alarm_in), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_data(reg_rd_data), .irq_n(irq_n)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rd_data;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wr_data = d; reg_wr_en = 1'b1;
    @(posedge clk);
    #0.5 reg_wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd1, d); check("R1 sticky after reset", d, 8'h00);
    rd(2'd2, d); check("R1 mask after reset", d, 8'h00);
    check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_live_and_edge();
    logic [7:0] d;
    @(negedge clk); alarm_in = 4'b1000;
    @(posedge clk); @(negedge clk);
    rd(2'd0, d); check("R2 live after one edge", d, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(2'd0, d); check("R2 live after two edges", d, 8'h80);
    rd(2'd1, d); check("R3 sticky not yet set", d, 8'h00);
    @(posedge clk); @(negedge clk);
    rd(2'd1, d); check("R3 sticky after three edges", d, 8'h80);
    check("R7 irq_n low, unmasked", {7'd0, irq_n}, 8'h00);
    wr(2'd1, 8'h80);
    settle(4);
    rd(2'd1, d); check("R10 held alarm does not re-set", d, 8'h00);
    check("R10 irq_n released", {7'd0, irq_n}, 8'h01);
    @(negedge clk); alarm_in = 4'b0000;
    settle(3);
  endtask

  task automatic t_hold_and_clear();
    logic [7:0] d;
    @(negedge clk); alarm_in = 4'b0001;
    settle(3);
    @(negedge clk); alarm_in = 4'b0000;
    settle(4);
    rd(2'd0, d); check("R4 live back low", d, 8'h00);
    rd(2'd1, d); check("R4 sticky held", d, 8'h10);
    wr(2'd1, 8'h00);
    rd(2'd1, d); check("R5 write 0 keeps bit", d, 8'h10);
    wr(2'd1, 8'hEF);
    rd(2'd1, d); check("R5 write 1 to other bits keeps bit", d, 8'h10);
    wr(2'd1, 8'h10);
    rd(2'd1, d); check("R5 write 1 clears", d, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    @(negedge clk); alarm_in = 4'b0010;
    @(posedge clk); @(posedge clk);
    wr(2'd1, 8'h20);
    rd(2'd1, d); check("R6 set beats clear", d, 8'h20);
    @(negedge clk); alarm_in = 4'b0000;
    settle(3);
    wr(2'd1, 8'h20);
    rd(2'd1, d); check("R6 later clear works", d, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] d;
    wr(2'd2, 8'hF0);
    @(negedge clk); alarm_in = 4'b1111;
    settle(3);
    rd(2'd1, d); check("R8 masked alarms still latch", d, 8'hF0);
    check("R7 irq_n high, all masked", {7'd0, irq_n}, 8'h01);
    wr(2'd2, 8'hE0);
    check("R7 irq_n low, bit4 unmasked", {7'd0, irq_n}, 8'h00);
    wr(2'd1, 8'h10);
    check("R7 irq_n high, unmasked bit cleared", {7'd0, irq_n}, 8'h01);
    wr(2'd1, 8'hE0);
    @(negedge clk); alarm_in = 4'b0000;
    settle(3);
  endtask

  task automatic t_readonly();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd2, d); check("R9 live write leaves mask", d, 8'hE0);
    rd(2'd1, d); check("R9 live write leaves sticky", d, 8'h00);
    rd(2'd0, d); check("R9 live write leaves live", d, 8'h00);
    rd(2'd3, d); check("R9 reserved address", d, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R9 mask reserved bits", d, 8'hF0);
    wr(2'd2, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_live_and_edge();
    t_hold_and_clear();
    t_priority();
    t_mask();
    t_readonly();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (R1..all) actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule